// File: doc/BRIEF.md
# NVM Command Controller with Security Lock

This block interprets a stream of words arriving on a valid-qualified input bus and applies them to a small bank of non-volatile configuration bits. It also drives a generic memory write port. In the idle state a word is read as an opcode. Set and clear opcodes take one following word as a bit mask. The get opcode answers with the current bits on a response port. The erase-all opcode wipes the bank. The memory write opcode takes an address word and then a burst of data beats, and the write address steps forward by itself after each beat.

A security opcode sets a sticky lock. From then on every command is refused, reads included. The only way out is to hold the external erase input high for longer than a time threshold, which is derived from the clock frequency parameter. A qualifying erase clears the lock and every configuration bit, and it pulses a memory-clear strobe. A shorter hold has no effect. The configuration bits and the lock model non-volatile storage, so they are not touched by reset. Reset only returns the command sequencer and the address register to their initial state.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: In the idle state, the word equal to the set opcode (default 0x0011) followed by one accepted mask word sets configuration bit i for every mask bit i (bits 0..NGP-1 of the word) that is 1. Other bits are unchanged.
- R2: The clear opcode (default 0x0012) followed by one mask word clears configuration bit i for every mask bit i that is 1. Other bits are unchanged.
- R3: The get opcode (default 0x0013) makes rsp_valid high for exactly the cycle after acceptance. rsp_data then holds configuration bit i in bit i, and zeros above NGP.
- R4: The erase-all opcode (default 0x0015) clears all configuration bits.
- R5: After the security opcode (default 0x0014), locked reads 1 from the next cycle. Every later word presented in the idle state gives a one-cycle err pulse and nothing else: no response, no memory write, and no change of the bits.
- R6: When erase_pin stays high for more than ERASE_MS milliseconds of CLK_HZ cycles, the lock and every configuration bit are cleared and mem_clr pulses once. A hold of exactly the threshold length, or shorter, changes nothing, and each release restarts the measurement.
- R7: The write opcode (default 0x0016), then an address word, then data beats: each beat drives mem_we high in its own cycle, with mem_wdata equal to the beat and mem_addr equal to the loaded address plus the number of earlier beats. A beat with in_last high ends the burst.
- R8: A new write command loads the address again from its first word after the opcode. Nothing carries over from the previous burst.
- R9: An opcode matching none of the six encodings gives a one-cycle err pulse and leaves the bits and the lock unchanged.
- R10: busy is high during a write burst and while erase_pin is held high. A word presented in the idle state while busy is high is ignored: no response and no err.
- R11: Reset returns the sequencer to idle and busy to 0. The configuration bits and the lock keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word on in_data is valid |
| in_data | input | W | Opcode, mask, address or data word |
| in_last | input | 1 | Marks the final data beat of a write burst |
| erase_pin | input | 1 | External erase request, level sensitive |
| busy | output | 1 | Write burst or erase hold in progress |
| rsp_valid | output | 1 | Get response strobe |
| rsp_data | output | W | Configuration bits returned by get |
| err | output | 1 | Unknown or refused command strobe |
| locked | output | 1 | Security lock state |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | W | Memory write data |
| mem_clr | output | 1 | Pulse when a qualifying erase completes |

## Verification
The hardest state to reach is the edge of the erase threshold. An erase that releases one cycle before the limit must leave a locked device locked, and one cycle more must unlock it. At the default clock this takes millions of cycles. The bench therefore sets the clock frequency parameter so that the threshold becomes 220 cycles. It holds the pin for exactly 220 and then 221 cycles while the lock is set. Random command mixes run before the lock is applied, and a reset is forced in the middle of a write burst.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MASK  = 2'd1,
    ST_WADDR = 2'd2,
    ST_WDATA = 2'd3
  } seq_state_e;

  typedef enum logic {
    MOP_SET = 1'b0,
    MOP_CLR = 1'b1
  } mask_op_e;

endpackage

// File: rtl/nvm_gp_store.sv
module nvm_gp_store #(
  parameter int NGP = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_en,
  input  logic           clr_en,
  input  logic           wipe_en,
  input  logic [NGP-1:0] mask,
  input  logic           lock_en,
  input  logic           erase_i,
  output logic [NGP-1:0] gp_o,
  output logic           secure_o
);

  logic [NGP-1:0] gp_q, gp_d;
  logic           gp_en;
  logic           sec_q, sec_d, sec_en;

  always_comb begin
    gp_en = erase_i | wipe_en | set_en | clr_en;
    gp_d  = gp_q;
    if (erase_i || wipe_en) gp_d = '0;
    else if (set_en)        gp_d = gp_q | mask;
    else if (clr_en)        gp_d = gp_q & ~mask;
    sec_en = erase_i | lock_en;
    sec_d  = !erase_i;
  end

  // storage models non-volatile cells: no reset, clock enable only
  always_ff @(posedge clk) begin
    if (gp_en)  gp_q  <= gp_d;
    if (sec_en) sec_q <= sec_d;
  end

  assign gp_o     = gp_q;
  assign secure_o = sec_q;

  // R5: once locked, the bits move only through an external erase
  a_r5_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q && !erase_i) |=> $stable(gp_q));

  // R6: a qualifying erase leaves the bank empty and unlocked
  a_r6_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (gp_q == '0 && !sec_q));

endmodule

// File: rtl/nvm_erase_qual.sv
module nvm_erase_qual #(
  parameter int CYC = 220
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic active_o,
  output logic fire_o
);

  localparam int CW = $clog2(CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(CYC);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!s2_q)            cnt_d = '0;
    else if (cnt_q <= LIMIT) cnt_d = cnt_q + 1'b1;
    else                  cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign active_o = s2_q;
  assign fire_o   = s2_q && (cnt_q == LIMIT);

  // R6: releasing the pin restarts the measurement
  a_r6_release_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_q |=> cnt_q == '0);

  // R6: one hold produces a single clear pulse
  a_r6_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

endmodule

// File: rtl/nvm_addr_ctr.sv
module nvm_addr_ctr #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load_i | step_i;
    addr_d  = load_i ? load_val : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R7: each beat without a reload advances by one word
  a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> addr_q == $past(addr_q) + 1'b1);

  // R8: a reload takes the supplied address
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> addr_q == $past(load_val));

endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
  import nvm_cmd_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          NGP      = 8,
  parameter int          AW       = 12,
  parameter int          CLK_HZ   = 36_000_000,
  parameter int          ERASE_MS = 220,
  parameter logic [W-1:0] OP_SET  = 16'h0011,
  parameter logic [W-1:0] OP_CLR  = 16'h0012,
  parameter logic [W-1:0] OP_GET  = 16'h0013,
  parameter logic [W-1:0] OP_SEC  = 16'h0014,
  parameter logic [W-1:0] OP_ERA  = 16'h0015,
  parameter logic [W-1:0] OP_WR   = 16'h0016
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic          in_last,
  input  logic          erase_pin,
  output logic          busy,
  output logic          rsp_valid,
  output logic [W-1:0]  rsp_data,
  output logic          err,
  output logic          locked,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          mem_clr
);

  localparam int ERASE_CYC = (CLK_HZ / 1000) * ERASE_MS;

  // reset synchronizer: asynchronous assert, synchronous release
  logic rs1_q, rs2_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s_n = rs2_q;

  seq_state_e     st_q, st_d;
  mask_op_e       mop_q, mop_d;
  logic           mop_en;
  logic           rsp_v_q, rsp_v_d;
  logic [W-1:0]   rsp_q, rsp_d;
  logic           err_q, err_d;

  logic           set_en, clr_en, wipe_en, lock_en;
  logic           ld_en, step_en;
  logic           er_active, er_fire;
  logic [NGP-1:0] gp_w;
  logic           sec_w;
  logic [AW-1:0]  addr_w;
  logic           take;

  nvm_erase_qual #(.CYC(ERASE_CYC)) u_erase (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .pin_i    (erase_pin),
    .active_o (er_active),
    .fire_o   (er_fire)
  );

  nvm_gp_store #(.NGP(NGP)) u_store (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .set_en   (set_en),
    .clr_en   (clr_en),
    .wipe_en  (wipe_en),
    .mask     (in_data[NGP-1:0]),
    .lock_en  (lock_en),
    .erase_i  (er_fire),
    .gp_o     (gp_w),
    .secure_o (sec_w)
  );

  nvm_addr_ctr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load_i   (ld_en),
    .load_val (in_data[AW-1:0]),
    .step_i   (step_en),
    .addr_o   (addr_w)
  );

  assign busy = er_active || (st_q == ST_WADDR) || (st_q == ST_WDATA);
  assign take = in_valid && !er_active;

  always_comb begin
    st_d    = st_q;
    mop_d   = mop_q;
    mop_en  = 1'b0;
    rsp_v_d = 1'b0;
    rsp_d   = rsp_q;
    err_d   = 1'b0;
    set_en  = 1'b0;
    clr_en  = 1'b0;
    wipe_en = 1'b0;
    lock_en = 1'b0;
    ld_en   = 1'b0;
    step_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (take) begin
          if (sec_w) begin
            err_d = 1'b1;
          end else if (in_data == OP_SET || in_data == OP_CLR) begin
            mop_en = 1'b1;
            mop_d  = (in_data == OP_SET) ? MOP_SET : MOP_CLR;
            st_d   = ST_MASK;
          end else if (in_data == OP_GET) begin
            rsp_v_d = 1'b1;
            rsp_d   = '0;
            rsp_d[NGP-1:0] = gp_w;
          end else if (in_data == OP_SEC) begin
            lock_en = 1'b1;
          end else if (in_data == OP_ERA) begin
            wipe_en = 1'b1;
          end else if (in_data == OP_WR) begin
            st_d = ST_WADDR;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_MASK: begin
        if (take) begin
          set_en = (mop_q == MOP_SET);
          clr_en = (mop_q == MOP_CLR);
          st_d   = ST_IDLE;
        end
      end
      ST_WADDR: begin
        if (take) begin
          ld_en = 1'b1;
          st_d  = ST_WDATA;
        end
      end
      ST_WDATA: begin
        if (take) begin
          step_en = 1'b1;
          if (in_last) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (er_fire) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q    <= ST_IDLE;
      mop_q   <= MOP_SET;
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      if (mop_en)  mop_q <= mop_d;
      rsp_v_q <= rsp_v_d;
      if (rsp_v_d) rsp_q <= rsp_d;
      err_q   <= err_d;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_q;
  assign err       = err_q;
  assign locked    = sec_w;
  assign mem_we    = (st_q == ST_WDATA) && take;
  assign mem_addr  = addr_w;
  assign mem_wdata = in_data;
  assign mem_clr   = er_fire;

  // R9: an error strobe never comes with a change of the bits or the lock
  a_r9_err_no_change: assert property (@(posedge clk) disable iff (!rst_s_n)
    err |-> (gp_w == $past(gp_w) && sec_w == $past(sec_w)));

  // R3: response, error and write strobes are mutually exclusive
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({rsp_valid, err, mem_we}));

  // R5: a locked controller neither answers nor writes memory
  a_r5_locked_silent: assert property (@(posedge clk) disable iff (!rst_s_n)
    locked |-> (!rsp_valid && !mem_we));

  // R10: a word met while busy in idle is not acted upon
  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && st_q == ST_IDLE) |=> (!rsp_valid && !err));

  // R7: memory writes only happen inside a busy burst
  a_r7_we_in_burst: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_we |-> busy);

endmodule

// File: tb/nvm_cmd_ctrl_test.sv
`timescale 1ns/1ps
module nvm_cmd_ctrl_test;

  localparam logic [15:0] OP_SET = 16'h0011;
  localparam logic [15:0] OP_CLR = 16'h0012;
  localparam logic [15:0] OP_GET = 16'h0013;
  localparam logic [15:0] OP_SEC = 16'h0014;
  localparam logic [15:0] OP_ERA = 16'h0015;
  localparam logic [15:0] OP_WR  = 16'h0016;
  localparam int THRESH = 220;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last, erase_pin;
  logic [15:0] in_data;
  logic        busy, rsp_valid, err, locked, mem_we, mem_clr;
  logic [15:0] rsp_data, mem_wdata;
  logic [11:0] mem_addr;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [7:0] gp_m;

  always #5 clk = ~clk;

  nvm_cmd_ctrl #(
    .W(16), .NGP(8), .AW(12), .CLK_HZ(1000), .ERASE_MS(220)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .erase_pin(erase_pin), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err(err), .locked(locked),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_clr(mem_clr)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic do_get(input string req, input logic expect_ok);
    send(OP_GET, 1'b0);
    if (expect_ok) begin
      check(rsp_valid == 1'b1 && err == 1'b0, req, {30'd0, rsp_valid, err}, 32'h2);
      check(rsp_data == {8'h00, gp_m}, req, rsp_data, {8'h00, gp_m});
    end else begin
      check(rsp_valid == 1'b0 && err == 1'b1, req, {30'd0, rsp_valid, err}, 32'h1);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input int n, input string req);
    send(OP_WR, 1'b0);
    check(busy == 1'b1, "R10 busy in burst", busy, 1);
    send({4'h0, a}, 1'b0);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_last = (i == n - 1);
      #1;
      check(mem_we == 1'b1 && mem_addr == 12'(a + i) && mem_wdata == d, req,
            {3'd0, mem_we, 4'd0, mem_addr, 12'd0}, {3'd0, 1'b1, 4'd0, 12'(a + i), 12'd0});
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check(busy == 1'b0 && mem_we == 1'b0, "R7 burst ends on last", busy, 0);
  endtask

  task automatic hold_erase(input int n, output int pulses);
    pulses = 0;
    @(negedge clk);
    erase_pin = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (mem_clr) pulses++;
    end
    erase_pin = 1'b0;
    repeat (5) begin
      @(negedge clk);
      if (mem_clr) pulses++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p;
    logic [7:0] m;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0; erase_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && rsp_valid == 1'b0 && err == 1'b0 && mem_we == 1'b0,
          "R11 reset state", {busy, rsp_valid, err, mem_we}, 0);

    // bring the non-volatile bits to a known state
    hold_erase(THRESH + 10, p);
    gp_m = 8'h00;
    check(p == 1 && locked == 1'b0, "R6 initial erase", p, 1);
    do_get("R3 empty bank", 1'b1);

    // directed: set and clear mapping
    send(OP_SET, 1'b0); send(16'h0081, 1'b0); gp_m = 8'h81;
    do_get("R1 set bits 0 and 7", 1'b1);
    send(OP_CLR, 1'b0); send(16'hFF01, 1'b0); gp_m = 8'h80;
    do_get("R2 clear bit 0", 1'b1);
    send(OP_ERA, 1'b0); gp_m = 8'h00;
    do_get("R4 erase-all", 1'b1);

    // random command mix
    for (int it = 0; it < 150; it++) begin
      int sel;
      sel = $urandom_range(0, 5);
      m = 8'($urandom);
      case (sel)
        0: begin send(OP_SET, 1'b0); send({8'($urandom), m}, 1'b0); gp_m = gp_m | m; end
        1: begin send(OP_CLR, 1'b0); send({8'($urandom), m}, 1'b0); gp_m = gp_m & ~m; end
        2: do_get("R3 random get", 1'b1);
        3: if ($urandom_range(0, 3) == 0) begin send(OP_ERA, 1'b0); gp_m = 8'h00; end
        4: begin
             send({8'h01, m}, 1'b0);
             check(err == 1'b1 && rsp_valid == 1'b0, "R9 unknown opcode err", err, 1);
           end
        default: do_write(12'($urandom), $urandom_range(1, 6), "R7 random burst");
      endcase
    end
    do_get("R9 bits after random mix", 1'b1);

    // address reload and wrap across bursts
    do_write(12'hFFE, 4, "R7 address wraps");
    do_write(12'h100, 2, "R8 reload address");

    // busy from erase pin: commands ignored
    @(negedge clk); erase_pin = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b1, "R10 busy while erase held", busy, 1);
    send(OP_GET, 1'b0);
    check(rsp_valid == 1'b0 && err == 1'b0, "R10 command ignored while busy",
          {rsp_valid, err}, 0);
    erase_pin = 1'b0;
    repeat (4) @(negedge clk);
    do_get("R10 bits kept after short hold", 1'b1);

    // reset during a burst keeps bits
    send(OP_SET, 1'b0); send(16'h005A, 1'b0); gp_m = gp_m | 8'h5A;
    send(OP_WR, 1'b0); send(16'h0040, 1'b0);
    check(busy == 1'b1, "R11 burst open before reset", busy, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R11 reset closes burst", busy, 0);
    do_get("R11 bits survive reset", 1'b1);

    // security lock
    send(OP_SEC, 1'b0);
    check(locked == 1'b1, "R5 lock set", locked, 1);
    send(OP_CLR, 1'b0);
    check(err == 1'b1, "R5 clear refused", err, 1);
    send(16'h00FF, 1'b0);
    check(err == 1'b1, "R5 mask word refused", err, 1);
    do_get("R5 get refused", 1'b0);
    send(OP_WR, 1'b0);
    check(err == 1'b1 && busy == 1'b0, "R5 write refused", {err, busy}, 2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(locked == 1'b1, "R11 lock survives reset", locked, 1);

    // erase threshold boundary
    hold_erase(100, p);
    check(p == 0 && locked == 1'b1, "R6 short hold no effect", p, 0);
    hold_erase(THRESH, p);
    check(p == 0 && locked == 1'b1, "R6 exact threshold no effect", p, 0);
    hold_erase(THRESH + 1, p);
    check(p == 1 && locked == 1'b0, "R6 threshold plus one clears", p, 1);
    gp_m = 8'h00;
    do_get("R6 bits wiped by erase", 1'b1);
    send(OP_SET, 1'b0); send(16'h0003, 1'b0); gp_m = 8'h03;
    do_get("R1 usable after unlock", 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule